// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo stream of twos-complement samples carried on three serial lines (a bit clock, a left/right framing clock and a data line) and turns it into a pair of parallel 24-bit words, left and right, announced by a one-cycle strobe. The serial lines come from another clock domain. They are brought into the system clock through two-stage synchronisers, and the bit clock is edge-detected there, so the bit clock must run well below half the system clock rate.

A 2-bit format input selects one of four framings: right-justified, I2S, left-justified, or a pulse framing in which a short high pulse on the framing line comes before each word. In right-justified framing a second 2-bit input selects the word length, and with it a fixed start offset inside the half frame. A word is handed over when the next word boundary arrives. This is the framing-clock transition in the three level framings, or the next pulse in pulse framing. The strobe fires once a left and then a right word of the same frame have both been handed over.

Top module: `serial_audio_rx`

## Requirements
- R1: The format input selects the framing as follows: 2'b00 right-justified (the value after reset), 2'b01 I2S, 2'b10 left-justified, 2'b11 pulse framing.
- R2: Each word arrives MSB first as a twos-complement value, and the left word precedes the right word. The output words keep the sign and bit order of the serial words.
- R3: In right-justified, left-justified and pulse framing, a high framing line marks the left channel. In I2S a low framing line marks the left channel.
- R4: In right-justified framing, counting the bit clock edge that first sees the new framing level as index 0, the MSB sits at index 8 when the length select is 2'b00 (24 bits), at index 12 for 2'b01 (20 bits) and at index 16 for 2'b10 or 2'b11 (16 bits). Exactly that many bits are taken.
- R5: Counting the same way, the MSB is at index 1 in I2S and at index 0 in left-justified framing.
- R6: In pulse framing, a high level of one or more bits on the framing line comes before each word, and the MSB is the first bit sampled low after it. The first pulse after reset starts a left word, and the channels alternate after that. Data is sampled on the falling bit clock edge in pulse framing and on the rising edge in the other three framings.
- R7: Outside right-justified framing any word length is accepted. Bits after the 24th of a word are dropped without side effect.
- R8: A word shorter than 24 bits is placed at the top of the 24-bit output, and the bits below it are zero.
- R9: The strobe is high for exactly one system clock, at the word boundary that ends the right word of a frame whose left word came first. Both outputs change only together with the strobe and hold their values in between.
- R10: After reset both outputs are zero and the strobe is low. The first word boundary after reset starts capture but hands nothing over, and a right word with no left word before it produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Left/right framing line |
| sdata_i | input | 1 | Serial data line |
| fmt_i | input | 2 | Framing select |
| rj_len_i | input | 2 | Word length select for right-justified framing |
| left_o | output | 24 | Left sample, MSB aligned |
| right_o | output | 24 | Right sample, MSB aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
A bit counter that starts at the wrong index shows up at the next strobe as a word shifted by one or more places. A wrong channel flag, or a wrong left-held flag, shows up as a missing, extra or swapped strobe at the next frame boundary. The bench makes the data line carry the complement of each bit during the half bit clock that should not be sampled. An edge selection error therefore corrupts every bit of the first frame and is visible at its strobe. Reset and arming faults show at the first boundary after reset, as a strobe that carries preamble data.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int W       = 24,
  parameter int CW      = 6,
  parameter int RJ_SLOT = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_i,
  input  logic         lrck_i,
  input  logic         sdata_i,
  input  logic [1:0]   fmt_i,
  input  logic [1:0]   rj_len_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  localparam logic [1:0] F_RJ  = 2'b00;
  localparam logic [1:0] F_I2S = 2'b01;
  localparam int         CMAX  = (1 << CW) - 1;

  logic [2:0]    bclk_q;
  logic [1:0]    lr_q, sd_q;
  logic          lr_prev, armed, have_left, dsp_right;
  logic [CW-1:0] cnt;
  logic [W-1:0]  word, left_hold, base, cap;
  int            rj_len, off, win, ec, pos, cnt_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_q <= '0;
      lr_q   <= '0;
      sd_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_i};
      lr_q   <= {lr_q[0], lrck_i};
      sd_q   <= {sd_q[0], sdata_i};
    end

  wire lr_s      = lr_q[1];
  wire sd_s      = sd_q[1];
  wire is_dsp    = (fmt_i == 2'b11);
  wire samp      = is_dsp ? (~bclk_q[1] & bclk_q[2]) : (bclk_q[1] & ~bclk_q[2]);
  wire left_lvl  = (fmt_i != F_I2S);
  wire trans     = (lr_s != lr_prev);
  wire restart   = is_dsp ? lr_s : trans;
  wire start_evt = is_dsp ? (lr_s & ~lr_prev) : trans;
  wire to_right  = is_dsp ? dsp_right : (lr_prev != left_lvl);
  wire take      = ~is_dsp | ~lr_s;

  always_comb begin
    case (rj_len_i)
      2'd0:    rj_len = W;
      2'd1:    rj_len = W - 4;
      default: rj_len = W - 8;
    endcase
    case (fmt_i)
      F_RJ:    begin off = RJ_SLOT - rj_len; win = rj_len; end
      F_I2S:   begin off = 1;                win = W;      end
      default: begin off = 0;                win = W;      end
    endcase
    ec   = restart ? 0 : int'(cnt);
    base = restart ? '0 : word;
    pos  = ec - off;
    cap  = base;
    if (take && pos >= 0 && pos < win)
      cap = base | ({{(W-1){1'b0}}, sd_s} << (W - 1 - pos));
    if (is_dsp && lr_s)  cnt_n = 0;
    else if (ec >= CMAX) cnt_n = CMAX;
    else                 cnt_n = ec + 1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lr_prev   <= 1'b0;
      cnt       <= '0;
      word      <= '0;
      armed     <= 1'b0;
      have_left <= 1'b0;
      dsp_right <= 1'b0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (samp) begin
        lr_prev <= lr_s;
        cnt     <= CW'(cnt_n);
        word    <= cap;
        if (start_evt) begin
          armed <= 1'b1;
          if (armed) begin
            if (!to_right) begin
              left_hold <= word;
              have_left <= 1'b1;
            end else if (have_left) begin
              left_o    <= left_hold;
              right_o   <= word;
              valid_o   <= 1'b1;
              have_left <= 1'b0;
            end
          end
          if (is_dsp) dsp_right <= armed ? ~dsp_right : 1'b0;
        end
      end
    end
endmodule

module serial_audio_rx_chk #(parameter int W = 24) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   fmt,
  input logic         valid,
  input logic [W-1:0] left,
  input logic [W-1:0] right,
  input logic         lr_s,
  input logic         samp
);
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({left, right}) |-> valid);
  assert_strobe_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(samp));
  assert_left_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(lr_s) == (fmt != 2'b01)));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt_i), .valid(valid_o),
  .left(left_o), .right(right_o), .lr_s(lr_s), .samp(samp)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic clk = 0, rst_n = 0, bclk = 0, lrck = 0, sdata = 0;
  logic [1:0] fmt = 0, rj_len = 0;
  logic [23:0] left_o, right_o;
  logic valid_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] ql[$], qr[$];
  string qt[$];

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .rj_len_i(rj_len), .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && valid_o) begin
    if (ql.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 R10 actual=unexpected strobe expected=none");
    end else begin
      string t; logic [23:0] el, er;
      el = ql.pop_front(); er = qr.pop_front(); t = qt.pop_front();
      check({t, " left"}, left_o, el);
      check({t, " right"}, right_o, er);
    end
  end

  function automatic logic [31:0] clip(input logic [31:0] w, input int wl);
    return (wl >= 32) ? w : (w & ((32'd1 << wl) - 1));
  endfunction

  function automatic logic [23:0] exp24(input logic [31:0] w, input int wl);
    logic [55:0] t;
    t = {24'd0, w};
    if (wl >= 24) t = t >> (wl - 24);
    else          t = t << (24 - wl);
    return t[23:0];
  endfunction

  function automatic logic wbit(input logic [31:0] w, input int wl, input int idx);
    return (idx >= 0 && idx < wl) ? w[wl-1-idx] : 1'b0;
  endfunction

  task automatic bit_out(input logic lr, input logic sd, input logic dsp);
    if (!dsp) begin
      lrck = lr; sdata = sd; bclk = 0;
      repeat (4) @(negedge clk);
      bclk = 1;
      repeat (2) @(negedge clk);
      sdata = ~sd;
      repeat (2) @(negedge clk);
    end else begin
      lrck = lr; sdata = ~sd; bclk = 1;
      repeat (2) @(negedge clk);
      sdata = sd;
      repeat (2) @(negedge clk);
      bclk = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] l);
    rst_n = 0; fmt = f; rj_len = l; bclk = (f == 2'b11); lrck = 0; sdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_half(input logic [1:0] f, input bit ch, input int half,
                           input int wl, input logic [31:0] w);
    logic lvl;
    lvl = (f == 2'b01) ? ch : !ch;
    for (int i = 0; i < half; i++) begin
      int idx;
      idx = (f == 2'b00) ? i - (half - wl) : (f == 2'b01) ? i - 1 : i;
      bit_out(lvl, wbit(w, wl, idx), 1'b0);
    end
  endtask

  task automatic frame(input logic [1:0] f, input int half, input int wl,
                       input logic [31:0] wl_in, input logic [31:0] wr_in, input string tag);
    logic [31:0] a, b;
    a = clip(wl_in, wl); b = clip(wr_in, wl);
    ql.push_back(exp24(a, wl)); qr.push_back(exp24(b, wl)); qt.push_back(tag);
    send_half(f, 0, half, wl, a);
    send_half(f, 1, half, wl, b);
  endtask

  task automatic finish_group(input string tag);
    repeat (40) @(negedge clk);
    n_chk++;
    if (ql.size() != 0) begin
      n_bad++;
      $display("FAIL %s R9 actual=%0d pending expected=0 pending", tag, ql.size());
    end
    ql.delete(); qr.delete(); qt.delete();
  endtask

  task automatic level_group(input logic [1:0] f, input logic [1:0] l, input int half,
                             input int wl, input int n, input string tag);
    do_reset(f, l);
    repeat (3) bit_out((f == 2'b01), 1'b1, 1'b0);
    for (int k = 0; k < n; k++) frame(f, half, wl, $urandom, $urandom, tag);
    bit_out((f != 2'b01), 1'b0, 1'b0);
    finish_group(tag);
  endtask

  task automatic dsp_word(input logic [31:0] w, input int wl, input int pw, input int gap);
    for (int i = 0; i < pw; i++) bit_out(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < wl; i++) bit_out(1'b0, w[wl-1-i], 1'b1);
    for (int i = 0; i < gap; i++) bit_out(1'b0, 1'b0, 1'b1);
  endtask

  task automatic dsp_group(input int wl, input int pw, input int gap, input int n, input string tag);
    do_reset(2'b11, 2'b00);
    repeat (2) bit_out(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a, b;
      a = clip($urandom, wl); b = clip($urandom, wl);
      ql.push_back(exp24(a, wl)); qr.push_back(exp24(b, wl)); qt.push_back(tag);
      dsp_word(a, wl, pw, gap);
      dsp_word(b, wl, pw, gap);
    end
    bit_out(1'b1, 1'b0, 1'b1);
    finish_group(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(2'b00, 2'b00);
    check("R10 reset left", left_o, 24'd0);
    check("R10 reset right", right_o, 24'd0);
    check("R10 reset strobe", {23'd0, valid_o}, 24'd0);

    // R2: sign extremes in left-justified framing
    do_reset(2'b10, 2'b00);
    repeat (3) bit_out(1'b0, 1'b1, 1'b0);
    frame(2'b10, 32, 24, 32'h800000, 32'h7FFFFF, "R2 extremes");
    frame(2'b10, 32, 24, 32'hFFFFFF, 32'h000001, "R2 extremes");
    bit_out(1'b1, 1'b0, 1'b0);
    finish_group("R2");

    level_group(2'b10, 2'b00, 32, 24, 3, "R5 left-justified");
    level_group(2'b10, 2'b00, 24, 24, 2, "R7 tight half");
    level_group(2'b10, 2'b00, 32, 30, 2, "R7 long word");
    level_group(2'b10, 2'b00, 32, 16, 2, "R8 short word");
    level_group(2'b01, 2'b00, 32, 24, 3, "R3 R5 I2S");
    level_group(2'b01, 2'b00, 32, 18, 2, "R8 I2S short");
    level_group(2'b01, 2'b00, 32, 28, 2, "R7 I2S long");
    level_group(2'b00, 2'b00, 32, 24, 3, "R1 R4 rj24");
    level_group(2'b00, 2'b01, 32, 20, 2, "R4 rj20");
    level_group(2'b00, 2'b10, 32, 16, 2, "R4 rj16");
    level_group(2'b00, 2'b11, 32, 16, 2, "R4 rj16 alt");
    dsp_group(24, 1, 0, 3, "R6 pulse");
    dsp_group(20, 2, 3, 2, "R6 R8 pulse short");
    dsp_group(32, 1, 2, 2, "R6 R7 pulse long");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule